// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked one-shot. It watches three asynchronous control pins. These are a falling-edge trigger, a rising-edge trigger and an active-low clear whose release can also fire. It drives a pulse output and that output's complement. The pulse width is a number of clock cycles taken from `width_i` when a trigger is accepted, so no external timing network is needed. A trigger that arrives during a pulse restarts the full width from that point, which lets a steady stream of triggers hold the output high for as long as the stream lasts. Triggers closer together than `MIN_RTRIG` cycles are dropped.

Each pin first passes through a two-flop synchroniser. A gating stage then compares each synchronised sample with the one from the previous cycle and decides whether an edge, together with the levels of the other two pins, forms a valid trigger. A three-state controller holds the pulse. Its states are `ST_IDLE` (no pulse), `ST_ACTIVE` (pulse high, width counter running) and `ST_BLOCKED` (clear pin low). Its transitions are:
- fire: `ST_IDLE` goes to `ST_ACTIVE`.
- reload: `ST_ACTIVE` goes to `ST_ACTIVE` on a trigger that is spaced far enough from the last one.
- expire: `ST_ACTIVE` goes to `ST_IDLE` when the counter is zero.
- block: `ST_IDLE` or `ST_ACTIVE` goes to `ST_BLOCKED` while the clear pin is low.
- release: `ST_BLOCKED` goes to `ST_IDLE` when the clear pin returns high.
- release-fire: `ST_BLOCKED` goes to `ST_ACTIVE` when the clear pin rises while the falling-edge pin is low and the rising-edge pin is high.

A dual part is built from two instances.

Top module: `rtrig_oneshot`

## Requirements
- R1: A falling edge on `trig_fall_i` starts a pulse when `trig_rise_i` is high and `clr_n_i` is high. `pulse_o` goes high on the third rising clock edge after the pin changes, and is still low at the edge before that.
- R2: A rising edge on `trig_rise_i` starts a pulse when `trig_fall_i` is low and `clr_n_i` is high, with the same three-edge latency as R1.
- R3: A rising edge on `clr_n_i` starts a pulse when `trig_fall_i` is low and `trig_rise_i` is high, with the same three-edge latency.
- R4: While `clr_n_i` is low, `pulse_o` is low from the third edge after the fall onward, and any running pulse is cut short. Trigger edges on the other pins are ignored during this time. Releasing `clr_n_i` without the R3 levels starts no pulse.
- R5: An accepted trigger during a pulse restarts the full width from that trigger. Triggers repeated at least `MIN_RTRIG` cycles apart, with gaps shorter than the width, keep `pulse_o` high without a break.
- R6: Static levels, and edges in the non-triggering direction (a rising `trig_fall_i` or a falling `trig_rise_i`), start no pulse. A pulse that has started runs to its end even if the inputs then settle into a non-triggering combination.
- R7: During a pulse, a trigger is ignored if it lands fewer than `MIN_RTRIG` cycles after the previous accepted trigger. A trigger exactly `MIN_RTRIG` cycles later is accepted. A trigger while no pulse runs is always accepted.
- R8: `pulse_n_o` is always the bitwise complement of `pulse_o`.
- R9: After the last accepted trigger, `pulse_o` stays high for exactly N cycles, where N is `width_i` sampled at that trigger. A value of 0 gives 1 cycle.
- R10: Synchronous reset `rst` clears the pulse and seeds the edge history from the current pin levels. Releasing reset while the pins already sit at triggering levels produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_i | input | 1 | Asynchronous trigger, acts on its falling edge |
| trig_rise_i | input | 1 | Asynchronous trigger, acts on its rising edge |
| clr_n_i | input | 1 | Asynchronous clear, active low; its rising edge can trigger |
| width_i | input | CNT_W | Pulse width in clock cycles (0 treated as 1) |
| pulse_o | output | 1 | Pulse output, active high |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The hardest case to reach from the pins is a retrigger that lands exactly at the spacing limit: `MIN_RTRIG` cycles after the previous accepted trigger, with a second at one cycle less. All three pins pass through synchronisers of the same depth, so the stimulus sets these gaps by counting cycles between pin changes. It returns the trigger pin to its idle level between the two edges. A similar case is a pulse started only by releasing the clear pin. The bench reaches it by raising the rising-edge pin while the clear is still low, so that edge is absorbed, and then releasing the clear with the falling-edge pin held low.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_BLOCKED = 2'd2
    } os_state_e;

    // Synchronised view of the three control pins
    typedef struct packed {
        logic fall_in;   // triggers on its falling edge
        logic rise_in;   // triggers on its rising edge
        logic clr_n;     // active-low clear, release can trigger
    } os_pins_t;

    localparam int PIN_COUNT = $bits(os_pins_t);

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] q;
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    q <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q <= async_i;   // seed with present level
                    else     q <= g_stage[s-1].q;
                end
            end
        end
    endgenerate

    assign sync_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/os_trig_gate.sv
module os_trig_gate
    import oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  os_pins_t lvl_i,    // synchronised levels
    input  os_pins_t seed_i,   // raw levels, used to seed history in reset
    output logic     fire_o,
    output logic     clr_n_o
);

    os_pins_t hist_q;
    logic     fire_fall;
    logic     fire_rise;
    logic     fire_rel;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= seed_i;
        else     hist_q <= lvl_i;
    end

    always_comb begin
        fire_fall = hist_q.fall_in & ~lvl_i.fall_in & lvl_i.rise_in  & lvl_i.clr_n;
        fire_rise = ~hist_q.rise_in & lvl_i.rise_in & ~lvl_i.fall_in & lvl_i.clr_n;
        fire_rel  = ~hist_q.clr_n & lvl_i.clr_n & ~lvl_i.fall_in & lvl_i.rise_in;
        fire_o    = fire_fall | fire_rise | fire_rel;
        clr_n_o   = lvl_i.clr_n;
    end

endmodule

// File: rtl/os_timer_fsm.sv
module os_timer_fsm
    import oneshot_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int MIN_RTRIG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic             clr_n_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int              GAP_W   = $clog2(MIN_RTRIG + 1);
    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(MIN_RTRIG);

    os_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
    logic [GAP_W-1:0] gap_q, gap_d;
    logic             gap_ok;
    logic             load;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            gap_q   <= GAP_SAT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            gap_q   <= gap_d;
        end
    end

    assign load_val = (width_i == '0) ? '0 : width_i - CNT_W'(1);
    assign gap_ok   = (gap_q >= GAP_SAT);

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        gap_d   = (gap_q < GAP_SAT) ? gap_q + GAP_W'(1) : gap_q;
        load    = 1'b0;
        unique case (state_q)
            ST_BLOCKED: begin
                if (clr_n_i) begin
                    if (fire_i) load    = 1'b1;      // release-fire
                    else        state_d = ST_IDLE;   // release
                end
            end
            ST_IDLE: begin
                if (!clr_n_i)    state_d = ST_BLOCKED;
                else if (fire_i) load    = 1'b1;     // fire
            end
            ST_ACTIVE: begin
                if (!clr_n_i)              state_d = ST_BLOCKED;
                else if (fire_i && gap_ok) load    = 1'b1;  // reload
                else if (cnt_q == '0)      state_d = ST_IDLE; // expire
                else                       cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
        if (load) begin
            state_d = ST_ACTIVE;
            cnt_d   = load_val;
            gap_d   = GAP_W'(1);
        end
    end

    // Outputs
    always_comb begin
        pulse_o = (state_q == ST_ACTIVE);
        cnt_o   = cnt_q;
    end

endmodule

// File: rtl/rtrig_oneshot.sv
module rtrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int MIN_RTRIG   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_fall_i,
    input  logic             trig_rise_i,
    input  logic             clr_n_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    os_pins_t         raw_pins;
    os_pins_t         sync_pins;
    logic             fire_any;
    logic             clr_n_s;
    logic             pulse_q;
    logic [CNT_W-1:0] cnt_q;

    assign raw_pins = '{fall_in: trig_fall_i, rise_in: trig_rise_i, clr_n: clr_n_i};

    os_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_pins),
        .sync_o  (sync_pins)
    );

    os_trig_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .lvl_i   (sync_pins),
        .seed_i  (raw_pins),
        .fire_o  (fire_any),
        .clr_n_o (clr_n_s)
    );

    os_timer_fsm #(.CNT_W(CNT_W), .MIN_RTRIG(MIN_RTRIG)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire_any),
        .clr_n_i (clr_n_s),
        .width_i (width_i),
        .pulse_o (pulse_q),
        .cnt_o   (cnt_q)
    );

    assign pulse_o   = pulse_q;
    assign pulse_n_o = ~pulse_q;

endmodule

// File: rtl/rtrig_oneshot_chk.sv
module rtrig_oneshot_chk #(
    parameter int CNT_W     = 8,
    parameter int MIN_RTRIG = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             pulse_o,
    input logic             pulse_n_o,
    input logic             clr_n_s,
    input logic             fire,
    input logic [CNT_W-1:0] cnt
);

    localparam int               SW    = $clog2(MIN_RTRIG + 1);
    localparam logic [SW-1:0]    S_SAT = SW'(MIN_RTRIG);

    logic             prev_pulse;
    logic [CNT_W-1:0] prev_cnt;
    logic [SW-1:0]    since;
    logic             start_now;
    logic             reload_now;

    assign start_now  = pulse_o && !prev_pulse;
    assign reload_now = pulse_o && prev_pulse && (cnt != prev_cnt - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pulse <= 1'b0;
            prev_cnt   <= '0;
            since      <= '0;
        end else begin
            prev_pulse <= pulse_o;
            prev_cnt   <= cnt;
            if (start_now || reload_now) since <= SW'(1);
            else if (since < S_SAT)      since <= since + SW'(1);
        end
    end

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        pulse_n_o == ~pulse_o);                                        // R8
    AST_CLEAR_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        !clr_n_s |=> !pulse_o);                                        // R4
    AST_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(fire));                               // R1
    AST_HOLD_WHILE_COUNTING: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && cnt != '0 && clr_n_s) |=> pulse_o);                // R5
    AST_RELOAD_SPACING: assert property (@(posedge clk) disable iff (rst)
        reload_now |-> (since >= S_SAT));                              // R7

endmodule

bind rtrig_oneshot rtrig_oneshot_chk #(.CNT_W(CNT_W), .MIN_RTRIG(MIN_RTRIG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o),
    .clr_n_s   (clr_n_s),
    .fire      (fire_any),
    .cnt       (cnt_q)
);

// File: tb/tb_rtrig_oneshot.sv
module tb_rtrig_oneshot;

    localparam int CW   = 8;
    localparam int MINR = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          pin_a, pin_b, pin_rd;
    logic [CW-1:0] width;
    logic          pulse_o, pulse_n_o;

    int  cyc    = 0;
    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    typedef struct {
        int    due;
        bit    q;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    rtrig_oneshot #(.CNT_W(CW), .MIN_RTRIG(MINR)) dut (
        .clk(clk), .rst(rst),
        .trig_fall_i(pin_a), .trig_rise_i(pin_b), .clr_n_i(pin_rd),
        .width_i(width), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    task automatic push(input int due, input bit q, input string tag);
        exp_t e;
        e.due = due; e.q = q; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pop due expectations and compare at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.due != cyc) begin
                fails++;
                $display("FAIL %s: slot for cycle %0d missed, actual cycle %0d expected %0d",
                         e.tag, e.due, cyc, e.due);
            end else if (pulse_o !== e.q) begin
                fails++;
                $display("FAIL %s: cycle %0d pulse_o actual %b expected %b",
                         e.tag, cyc, pulse_o, e.q);
            end else if (pulse_n_o !== ~e.q) begin
                fails++;
                $display("FAIL R8 (in %s): cycle %0d pulse_n_o actual %b expected %b",
                         e.tag, cyc, pulse_n_o, ~e.q);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // Driver
    initial begin
        int c0, c1, c2, cb;
        rst = 1'b1; pin_a = 1'b0; pin_b = 1'b1; pin_rd = 1'b1; width = CW'(6);
        wait_cyc(3);
        rst = 1'b0;
        // R10: reset with triggering levels on the pins fires nothing
        c0 = cyc;
        push(c0 + 1, 0, "R10"); push(c0 + 3, 0, "R10"); push(c0 + 6, 0, "R10");
        wait_cyc(8);

        // R6: falling trigger_rise pin does nothing; then R2 rising edge fires
        c0 = cyc; pin_b = 1'b0; push(c0 + 4, 0, "R6");
        wait_cyc(6);
        c0 = cyc; pin_b = 1'b1;
        push(c0 + 2, 0, "R2"); push(c0 + 3, 1, "R2");
        push(c0 + 8, 1, "R9"); push(c0 + 9, 0, "R9");
        wait_cyc(12);

        // R6: rising trigger_fall pin does nothing; then R1 falling edge fires
        c0 = cyc; pin_a = 1'b1; push(c0 + 4, 0, "R6");
        wait_cyc(6);
        c0 = cyc; pin_a = 1'b0;
        push(c0 + 2, 0, "R1"); push(c0 + 3, 1, "R1");
        push(c0 + 8, 1, "R6"); push(c0 + 9, 0, "R6");
        wait_cyc(2);
        pin_b = 1'b0;           // non-triggering combination, pulse continues
        wait_cyc(10);

        // R4 then R3: edge absorbed while cleared, release fires
        pin_rd = 1'b0;
        wait_cyc(2);
        cb = cyc; pin_b = 1'b1; push(cb + 4, 0, "R4");
        wait_cyc(4);
        c0 = cyc; pin_rd = 1'b1;
        push(c0 + 2, 0, "R3"); push(c0 + 3, 1, "R3"); push(c0 + 9, 0, "R3");
        wait_cyc(12);

        // R4: clear cuts a long pulse, blocks triggers, plain release is silent
        width = CW'(20);
        pin_b = 1'b0;
        wait_cyc(4);
        c0 = cyc; pin_b = 1'b1; push(c0 + 3, 1, "R4");
        wait_cyc(5);
        c1 = cyc; pin_rd = 1'b0;
        push(c1 + 2, 1, "R4"); push(c1 + 3, 0, "R4");
        wait_cyc(3);
        pin_a = 1'b1;
        wait_cyc(2);
        pin_b = 1'b0;
        wait_cyc(2);
        cb = cyc; pin_b = 1'b1;
        push(cb + 3, 0, "R4"); push(cb + 6, 0, "R4");
        wait_cyc(4);
        c2 = cyc; pin_rd = 1'b1;
        push(c2 + 4, 0, "R4"); push(c2 + 8, 0, "R4");
        wait_cyc(10);
        width = CW'(6);

        // R5: one accepted retrigger extends the pulse
        c0 = cyc; pin_a = 1'b0; push(c0 + 3, 1, "R5");
        wait_cyc(2);
        pin_a = 1'b1;
        wait_cyc(3);
        pin_a = 1'b0;
        push(c0 + 9, 1, "R5"); push(c0 + 13, 1, "R5"); push(c0 + 14, 0, "R5");
        wait_cyc(16);

        // R7: retrigger three cycles later is dropped
        pin_b = 1'b0;
        wait_cyc(4);
        c0 = cyc; pin_b = 1'b1; push(c0 + 3, 1, "R7");
        wait_cyc(1);
        pin_b = 1'b0;
        wait_cyc(2);
        pin_b = 1'b1;
        push(c0 + 8, 1, "R7"); push(c0 + 9, 0, "R7");
        wait_cyc(12);

        // R7: retrigger exactly MINR cycles later is accepted
        pin_b = 1'b0;
        wait_cyc(4);
        c0 = cyc; pin_b = 1'b1; push(c0 + 3, 1, "R7");
        wait_cyc(2);
        pin_b = 1'b0;
        wait_cyc(MINR - 2);
        pin_b = 1'b1;
        push(c0 + MINR + 8, 1, "R7"); push(c0 + MINR + 9, 0, "R7");
        wait_cyc(16);

        // R5: a stream of triggers holds the output high
        pin_b = 1'b0;
        wait_cyc(4);
        c0 = cyc;
        for (int k = 0; k < 8; k++) push(c0 + 3 + 5 * k, 1, "R5");
        push(c0 + 43, 1, "R5"); push(c0 + 44, 0, "R5");
        for (int k = 0; k < 8; k++) begin
            pin_b = 1'b1;
            wait_cyc(2);
            pin_b = 1'b0;
            wait_cyc(3);
        end
        wait_cyc(12);

        // R9: zero width gives a single cycle
        width = '0;
        c0 = cyc; pin_b = 1'b1;
        push(c0 + 2, 0, "R9"); push(c0 + 3, 1, "R9"); push(c0 + 4, 0, "R9");
        wait_cyc(8);

        while (sb.size() > 0) wait_cyc(1);
        summary();
    end

endmodule